// File: doc/BRIEF.md
# Destination Address Screen

This block decides, frame by frame, whether a received Ethernet frame is addressed to this station. It watches the receive byte stream. When it sees a start-of-frame strobe, it captures the first six bytes as the 48-bit destination address. While those bytes arrive, it runs a reflected CRC-32 over them, one byte per clock cycle.

Once the sixth byte has been taken, the block classifies the address as unicast, multicast or broadcast. It then applies the acceptance route that fits that class:

- exact comparison against the programmed station address;
- blanket acceptance of broadcasts;
- blanket acceptance of multicasts;
- a 64-bin multicast hash lookup.

Each route has its own enable input. The station address and the hash table are plain inputs, held stable by the surrounding logic.

A registered verdict comes out one cycle after the sixth address byte. It stays until the next frame begins. Payload bytes after the address have no effect, and checking the frame check sequence is left to other logic.

Top module: `dest_addr_screen`

## Requirements
- R1: While `rst` is sampled high, the next clock edge leaves `verdict_vld` and `verdict_acc` at 0.
- R2: A frame starts on an edge that samples `sof` and `byte_vld` both high, and that byte is address byte 0. The next five edges with `byte_vld` high supply bytes 1 to 5, and idle cycles may fall between them. After byte 5, `byte_vld` has no effect until the next start. `byte_vld` without any earlier start after reset has no effect.
- R3: `verdict_vld` rises on the edge after the one that samples address byte 5. The verdict then holds `verdict_vld` high and `verdict_acc` unchanged until the next start of frame.
- R4: An edge that starts a frame drops `verdict_vld`. The exception is an edge that also issues the previous frame's verdict. That verdict is then issued, `verdict_vld` stays high, and the value is replaced when the new frame's own verdict is issued.
- R5: A frame cut short by a new start before its sixth byte produces no verdict.
- R6: An address with bit 0 of byte 0 clear is unicast. It is accepted only if `en_uni` and `en_exact` are both 1 and the address equals the station address. Byte i of the station address is `sta_lo[8i+7:8i]` for i = 0 to 3, byte 4 is `sta_hi[7:0]` and byte 5 is `sta_hi[15:8]`.
- R7: An address whose 48 bits are all 1 is broadcast. It is accepted exactly when `en_bcast` is 1, whatever the multicast and hash enables say.
- R8: Any other address with bit 0 of byte 0 set is multicast. It is accepted when `en_mcast_all` is 1.
- R9: A multicast address is also accepted when `en_hash` is 1 and the selected table bit is 1. To form the index, a CRC-32 starts at all ones and absorbs the six bytes in arrival order, least significant bit first, with the reflected polynomial 0xEDB88320. The result is inverted, and bits 28 down to 23 of the inverted value give an index k from 0 to 63.
- R10: Index k selects bit k of `hash_lo` when k is below 32. Otherwise it selects bit k-32 of `hash_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame strobe, qualified by `byte_vld` |
| byte_vld | input | 1 | Receive byte valid |
| byte_dat | input | 8 | Receive byte |
| sta_lo | input | 32 | Station address bytes 0 to 3 |
| sta_hi | input | 16 | Station address bytes 4 and 5 |
| hash_lo | input | 32 | Hash table bins 0 to 31 |
| hash_hi | input | 32 | Hash table bins 32 to 63 |
| en_uni | input | 1 | Unicast acceptance enable |
| en_mcast_all | input | 1 | Accept every multicast |
| en_bcast | input | 1 | Broadcast acceptance enable |
| en_hash | input | 1 | Multicast hash acceptance enable |
| en_exact | input | 1 | Exact station address comparison enable |
| verdict_vld | output | 1 | A verdict for the current frame is present |
| verdict_acc | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
Two events can share one clock edge. The first is the issue of one frame's verdict. The second is the start-of-frame byte of the next frame, which would otherwise clear the verdict.

The bench provokes this by sending a frame immediately behind another, so the new start is sampled on the edge that issues the previous verdict. It judges the result by requiring that `verdict_vld` never drops. `verdict_acc` must carry the earlier frame's value until the new frame's verdict arrives, and the two frames are chosen to have opposite verdicts so that a swap is visible.

// File: rtl/das_pkg.sv
package das_pkg;

  typedef enum logic [1:0] {
    CLS_UNICAST   = 2'd0,
    CLS_MULTICAST = 2'd1,
    CLS_BROADCAST = 2'd2
  } dest_class_e;

  // One byte through a reflected CRC, least significant bit first.
  function automatic logic [31:0] crc_refl_byte(input logic [31:0] cur,
                                                input logic [7:0]  dat,
                                                input logic [31:0] poly);
    logic [31:0] c;
    c = cur ^ {24'd0, dat};
    for (int b = 0; b < 8; b++) begin
      if (c[0]) c = (c >> 1) ^ poly;
      else      c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/das_addr_collect.sv
module das_addr_collect #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sof,
  input  logic                    byte_vld,
  input  logic [7:0]              byte_dat,
  output logic                    take,
  output logic                    take_first,
  output logic                    done,
  output logic [ADDR_BYTES*8-1:0] addr
);
  localparam int CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] FULL = CW'(ADDR_BYTES);
  localparam logic [CW-1:0] LAST = CW'(ADDR_BYTES - 1);

  logic [CW-1:0] cnt;
  logic          start;
  logic          more;
  logic [CW-1:0] idx;

  assign start      = sof & byte_vld;
  assign more       = byte_vld & ~sof & (cnt < FULL);
  assign idx        = start ? '0 : cnt;
  assign take       = start | more;
  assign take_first = start;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= FULL;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt  <= CW'(1);
        done <= (ADDR_BYTES == 1);
      end else if (more) begin
        cnt <= cnt + CW'(1);
        if (cnt == LAST) done <= 1'b1;
      end
    end
  end

  // One byte lane per address byte; each loads when the count points at it.
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        addr[g*8 +: 8] <= '0;
      end else if (take && idx == CW'(g)) begin
        addr[g*8 +: 8] <= byte_dat;
      end
    end
  end

endmodule

// File: rtl/das_crc_accum.sv
module das_crc_accum #(
  parameter logic [31:0] POLY      = 32'hEDB88320,
  parameter int          HASH_BITS = 6,
  parameter int          HASH_LSB  = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take,
  input  logic                 take_first,
  input  logic [7:0]           byte_dat,
  output logic [HASH_BITS-1:0] hash_idx
);
  import das_pkg::*;

  logic [31:0] crc_q;
  logic [31:0] seed;

  // A new frame restarts the running value from all ones.
  assign seed = take_first ? 32'hFFFF_FFFF : crc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= 32'hFFFF_FFFF;
    end else if (take) begin
      crc_q <= crc_refl_byte(seed, byte_dat, POLY);
    end
  end

  assign hash_idx = ~crc_q[HASH_LSB +: HASH_BITS];

endmodule

// File: rtl/das_verdict.sv
module das_verdict #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_start,
  input  logic                    addr_done,
  input  logic [ADDR_BYTES*8-1:0] addr,
  input  logic [HASH_BITS-1:0]    hash_idx,
  input  logic [ADDR_BYTES*8-1:0] station,
  input  logic [(2**HASH_BITS)/2-1:0] hash_lo,
  input  logic [(2**HASH_BITS)/2-1:0] hash_hi,
  input  logic                    en_uni,
  input  logic                    en_mcast_all,
  input  logic                    en_bcast,
  input  logic                    en_hash,
  input  logic                    en_exact,
  output logic                    verdict_vld,
  output logic                    verdict_acc
);
  import das_pkg::*;

  localparam int SEL_BITS = HASH_BITS - 1;

  dest_class_e cls;
  logic        bin_hit;
  logic        uni_ok;
  logic        accept;
  logic [SEL_BITS-1:0] bit_sel;

  always_comb begin
    if (&addr)        cls = CLS_BROADCAST;
    else if (addr[0]) cls = CLS_MULTICAST;
    else              cls = CLS_UNICAST;
  end

  // Top index bit picks the table word, the rest the bit within it.
  assign bit_sel = hash_idx[SEL_BITS-1:0];
  assign bin_hit = hash_idx[HASH_BITS-1] ? hash_hi[bit_sel] : hash_lo[bit_sel];
  assign uni_ok  = en_uni & en_exact & (addr == station);

  always_comb begin
    unique case (cls)
      CLS_BROADCAST: accept = en_bcast;
      CLS_MULTICAST: accept = en_mcast_all | (en_hash & bin_hit);
      default:       accept = uni_ok;
    endcase
  end

  // Issuing a verdict wins over the clear from a start on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      verdict_vld <= 1'b0;
      verdict_acc <= 1'b0;
    end else if (addr_done) begin
      verdict_vld <= 1'b1;
      verdict_acc <= accept;
    end else if (frame_start) begin
      verdict_vld <= 1'b0;
    end
  end

endmodule

// File: rtl/dest_addr_screen.sv
module dest_addr_screen #(
  parameter int          ADDR_BYTES = 6,
  parameter int          HASH_BITS  = 6,
  parameter int          HASH_LSB   = 23,
  parameter logic [31:0] CRC_POLY   = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sof,
  input  logic        byte_vld,
  input  logic [7:0]  byte_dat,
  input  logic [31:0] sta_lo,
  input  logic [ADDR_BYTES*8-33:0] sta_hi,
  input  logic [(2**HASH_BITS)/2-1:0] hash_lo,
  input  logic [(2**HASH_BITS)/2-1:0] hash_hi,
  input  logic        en_uni,
  input  logic        en_mcast_all,
  input  logic        en_bcast,
  input  logic        en_hash,
  input  logic        en_exact,
  output logic        verdict_vld,
  output logic        verdict_acc
);
  localparam int ADDR_W = ADDR_BYTES * 8;

  logic                 frame_take;
  logic                 frame_start;
  logic                 addr_done;
  logic [ADDR_W-1:0]    addr_bus;
  logic [HASH_BITS-1:0] hash_idx;
  logic [ADDR_W-1:0]    station;

  assign station = {sta_hi, sta_lo};

  das_addr_collect #(.ADDR_BYTES(ADDR_BYTES)) u_collect (
    .clk        (clk),
    .rst        (rst),
    .sof        (sof),
    .byte_vld   (byte_vld),
    .byte_dat   (byte_dat),
    .take       (frame_take),
    .take_first (frame_start),
    .done       (addr_done),
    .addr       (addr_bus)
  );

  das_crc_accum #(.POLY(CRC_POLY), .HASH_BITS(HASH_BITS), .HASH_LSB(HASH_LSB)) u_crc (
    .clk        (clk),
    .rst        (rst),
    .take       (frame_take),
    .take_first (frame_start),
    .byte_dat   (byte_dat),
    .hash_idx   (hash_idx)
  );

  das_verdict #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_verdict (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .addr_done    (addr_done),
    .addr         (addr_bus),
    .hash_idx     (hash_idx),
    .station      (station),
    .hash_lo      (hash_lo),
    .hash_hi      (hash_hi),
    .en_uni       (en_uni),
    .en_mcast_all (en_mcast_all),
    .en_bcast     (en_bcast),
    .en_hash      (en_hash),
    .en_exact     (en_exact),
    .verdict_vld  (verdict_vld),
    .verdict_acc  (verdict_acc)
  );

endmodule

// File: rtl/addr_screen_chk.sv
module addr_screen_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_start,
  input logic              addr_done,
  input logic [ADDR_W-1:0] addr_bus,
  input logic              en_bcast,
  input logic              en_uni,
  input logic              en_exact,
  input logic              verdict_vld,
  input logic              verdict_acc
);
  logic past_rst = 1'b0;
  always_ff @(posedge clk) past_rst <= rst;

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    past_rst |-> (!verdict_vld && !verdict_acc));

  // R3
  a_r3_issue: assert property (@(posedge clk) disable iff (rst)
    addr_done |=> verdict_vld);

  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (verdict_vld && !frame_start && !addr_done) |=> (verdict_vld && $stable(verdict_acc)));

  // R4
  a_r4_start_clears: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !addr_done) |=> !verdict_vld);

  // R6
  a_r6_uni_needs_both: assert property (@(posedge clk) disable iff (rst)
    (addr_done && !addr_bus[0] && !(en_uni && en_exact)) |=> !verdict_acc);

  // R7
  a_r7_bcast_route: assert property (@(posedge clk) disable iff (rst)
    (addr_done && (&addr_bus)) |=> (verdict_acc == $past(en_bcast)));

endmodule

bind dest_addr_screen addr_screen_chk #(.ADDR_W(48)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .addr_done   (addr_done),
  .addr_bus    (addr_bus),
  .en_bcast    (en_bcast),
  .en_uni      (en_uni),
  .en_exact    (en_exact),
  .verdict_vld (verdict_vld),
  .verdict_acc (verdict_acc)
);

// File: tb/sim_dest_addr_screen.sv
`timescale 1ns/1ps
module sim_dest_addr_screen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sof = 1'b0, byte_vld = 1'b0;
  logic [7:0]  byte_dat = '0;
  logic [31:0] sta_lo = '0;
  logic [15:0] sta_hi = '0;
  logic [31:0] hash_lo = '0, hash_hi = '0;
  logic        en_uni = 0, en_mcast_all = 0, en_bcast = 0, en_hash = 0, en_exact = 0;
  logic        verdict_vld, verdict_acc;

  always #10 clk = ~clk;

  dest_addr_screen u0 (
    .clk(clk), .rst(rst), .sof(sof), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .sta_lo(sta_lo), .sta_hi(sta_hi), .hash_lo(hash_lo), .hash_hi(hash_hi),
    .en_uni(en_uni), .en_mcast_all(en_mcast_all), .en_bcast(en_bcast),
    .en_hash(en_hash), .en_exact(en_exact),
    .verdict_vld(verdict_vld), .verdict_acc(verdict_acc)
  );

  int    n_chk = 0, n_err = 0, cyc = 0;
  bit    done_flag = 0;
  string cur_req = "R1";

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Reference CRC: bit-serial over the 48 address bits, LSB of byte 0 first.
  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] r;
    logic        fb;
    r = 32'hFFFF_FFFF;
    for (int b = 0; b < 48; b++) begin
      fb = r[0] ^ a[b];
      r  = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    r = ~r;
    return r[28:23];
  endfunction

  function automatic logic ref_accept(input logic [47:0] a);
    logic [5:0] k;
    logic [63:0] tbl;
    if (a == 48'hFFFF_FFFF_FFFF) return en_bcast;
    if (a[0]) begin
      k   = ref_idx(a);
      tbl = {hash_hi, hash_lo};
      return en_mcast_all || (en_hash && tbl[k]);
    end
    return en_uni && en_exact && (a == {sta_hi, sta_lo});
  endfunction

  // Cycle-by-cycle behavioural reference
  logic        m_vld = 0, m_acc = 0, m_done = 0, m_issue;
  int          m_cnt = 6;
  logic [47:0] m_addr = '0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_vld = 0; m_acc = 0; m_cnt = 6; m_done = 0;
    end else begin
      m_issue = m_done;
      m_done  = 0;
      if (m_issue) begin
        m_vld = 1; m_acc = ref_accept(m_addr);
      end else if (sof && byte_vld) begin
        m_vld = 0;
      end
      if (sof && byte_vld) begin
        m_addr[7:0] = byte_dat; m_cnt = 1;
      end else if (byte_vld && m_cnt < 6) begin
        m_addr[m_cnt*8 +: 8] = byte_dat;
        m_cnt++;
        if (m_cnt == 6) m_done = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      check(cur_req, verdict_vld, m_vld);
      check(cur_req, verdict_acc, m_acc);
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 50000 && !done_flag) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sof = 0; byte_vld = 0;
    end
  endtask

  // Caller stands at a negedge; returns at the negedge after byte 5 is sampled.
  task automatic send_frame(input logic [47:0] a, input int gap, input int nbytes);
    for (int i = 0; i < nbytes; i++) begin
      if (i > 0) @(negedge clk);
      sof = (i == 0); byte_vld = 1; byte_dat = a[i*8 +: 8];
      if (i < nbytes - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk); sof = 0; byte_vld = 0;
        end
      end
    end
    @(negedge clk); sof = 0; byte_vld = 0;
  endtask

  task automatic frame_and_judge(input string req, input logic [47:0] a);
    logic e;
    send_frame(a, 0, 6);
    @(negedge clk);
    e = ref_accept(a);
    check(req, verdict_vld, 1'b1);
    check(req, verdict_acc, e);
    idle(1);
  endtask

  localparam logic [47:0] STA   = 48'h5544_3322_1102;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  logic [47:0] mc_lo, mc_hi, cand;
  logic [5:0]  k_lo, k_hi, kk;
  bit          got_lo, got_hi;

  initial begin
    got_lo = 0; got_hi = 0; mc_lo = '0; mc_hi = '0; k_lo = '0; k_hi = '0;
    for (int n = 0; n < 256; n++) begin
      cand = {n[7:0], 8'h00, 8'h00, 8'h5e, 8'h00, 8'h01};
      kk = ref_idx(cand);
      if (!got_lo && kk < 32) begin got_lo = 1; mc_lo = cand; k_lo = kk; end
      if (!got_hi && kk >= 32) begin got_hi = 1; mc_hi = cand; k_hi = kk; end
    end

    repeat (3) @(negedge clk);
    check("R1", verdict_vld, 1'b0);
    check("R1", verdict_acc, 1'b0);
    rst = 0;

    cur_req = "R2";
    sta_lo = STA[31:0]; sta_hi = STA[47:32]; en_bcast = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); byte_vld = 1; byte_dat = 8'hFF;
    end
    idle(3);
    check("R2 stray bytes", verdict_vld, 1'b0);

    cur_req = "R6";
    en_bcast = 0; en_uni = 1; en_exact = 1;
    frame_and_judge("R6 station match", STA);
    check("R6 station match accepted", verdict_acc, 1'b1);
    en_exact = 0;
    frame_and_judge("R6 exact off", STA);
    en_exact = 1;
    frame_and_judge("R6 mismatch", STA ^ 48'h0100_0000_0000);

    cur_req = "R7";
    en_bcast = 1;
    frame_and_judge("R7 bcast on", BCAST);
    en_bcast = 0; en_mcast_all = 1; en_hash = 1; hash_lo = '1; hash_hi = '1;
    frame_and_judge("R7 bcast off", BCAST);
    check("R7 bcast off rejected", verdict_acc, 1'b0);

    cur_req = "R8";
    hash_lo = '0; hash_hi = '0; en_hash = 0;
    frame_and_judge("R8 all multicast", mc_lo);
    en_mcast_all = 0;
    frame_and_judge("R8 all multicast off", mc_lo);

    cur_req = "R9";
    en_hash = 1;
    hash_lo = 32'd1 << k_lo[4:0];
    frame_and_judge("R9 hash bin set", mc_lo);
    check("R9 hash bin set accepted", verdict_acc, 1'b1);
    hash_lo = ~(32'd1 << k_lo[4:0]); hash_hi = '1;
    frame_and_judge("R9 hash bin clear", mc_lo);

    cur_req = "R10";
    hash_lo = '0; hash_hi = 32'd1 << k_hi[4:0];
    frame_and_judge("R10 high word", mc_hi);
    check("R10 high word accepted", verdict_acc, 1'b1);
    hash_lo = 32'd1 << k_hi[4:0]; hash_hi = '0;
    frame_and_judge("R10 low word mirror", mc_hi);

    cur_req = "R3";
    send_frame(STA, 2, 6);
    check("R3 not before", verdict_vld, 1'b0);
    for (int p = 0; p < 4; p++) begin
      byte_vld = 1; byte_dat = 8'hA5; sof = 0;
      @(negedge clk);
      check("R3 held during payload", verdict_vld, 1'b1);
      check("R3 held during payload", verdict_acc, 1'b1);
    end
    idle(2);

    cur_req = "R4";
    send_frame(STA, 0, 6);
    send_frame(BCAST, 0, 6);
    check("R4 kept over start", verdict_vld, 1'b1);
    check("R4 kept over start", verdict_acc, 1'b1);
    @(negedge clk);
    check("R4 replaced", verdict_vld, 1'b1);
    check("R4 replaced", verdict_acc, 1'b0);
    idle(2);

    cur_req = "R5";
    send_frame(STA, 0, 3);
    idle(3);
    check("R5 short frame", verdict_vld, 1'b0);
    send_frame(mc_lo, 1, 6);
    idle(2);
    check("R5 next frame judged alone", verdict_acc, 1'b0);
    idle(2);

    finish_run();
  end
endmodule